// File: doc/BRIEF.md
# Serial Wiper-Position Slave

This block is a two-wire serial slave that holds the wiper settings of three potentiometer channels with different tap counts: 64, 100 and 256 taps. A bus master addresses it with a fixed 7-bit device address. The master then sends an instruction byte that picks a channel, and after that either a data byte to store or a repeated START that reads the selected setting back. The three settings are always visible as parallel outputs, so the analog network next to the block can follow them directly.

The block oversamples SCL and SDA on its own system clock. It finds START and STOP from SDA edges that occur while SCL is high. It pulls SDA low only through an open-drain enable, and it changes that enable only while SCL is low. The read channel is kept in a pointer that the last accepted instruction byte sets. A read that follows a "dummy" write therefore returns the channel that the dummy write named.

Top module: `i2c_wiper_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper 7 bits equal 1010111. Any other address is not acknowledged, and the slave ignores every following byte until the next START.
- R2: The instruction byte selects the channel with bits [1:0] (00 = channel 0, 01 = channel 1, 10 = channel 2) and is acknowledged. Bit [2] is the write-type flag and has no effect on the stored settings.
- R3: An instruction byte with bits [1:0] = 11 is not acknowledged. It changes no setting and leaves the read pointer at its previous channel.
- R4: In a write, the data byte is acknowledged and replaces the selected setting in the acknowledge clock, whatever its previous value.
- R5: Channel 0 keeps the low 6 bits of the data byte. Channel 1 keeps 7 bits, and a data value above 99 is stored as 99. Channel 2 keeps all 8 bits.
- R6: After address-write, instruction, repeated START and address-read (the address byte with bit 0 = 1), the slave sends the setting of the channel in bits [1:0], MSB first. The write-type bit is ignored. The unused upper bits of channels 0 and 1 read as 0.
- R7: After reset all three settings are 0, the lowest tap.
- R8: The slave changes its SDA drive only while SCL is low.
- R9: A START seen in the middle of a transfer aborts it and begins a new address byte. A STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| wiper0 | output | 6 | Channel 0 setting (64 taps) |
| wiper1 | output | 7 | Channel 1 setting (100 taps) |
| wiper2 | output | 8 | Channel 2 setting (256 taps) |

## Verification
The acknowledge clock that ends a write data byte does two things in the same SCL period: the slave holds SDA low, and it commits the selected setting. The bench drives byte writes to every channel, including a channel 1 value above 99. It checks both the sampled acknowledge bit and the parallel output that follows the STOP. A second coincidence occurs at the falling SCL edge that closes the address acknowledge of a read. At that edge the slave must release its acknowledge and, in the same step, present the first data bit. The scoreboard compares every received byte against the value queued from the requirements.

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'b1010111,
  parameter int         SYNC_DEPTH = 2,
  parameter int         CH0_BITS   = 6,
  parameter int         CH1_BITS   = 7,
  parameter int         CH2_BITS   = 8,
  parameter int         CH1_TOP    = 99
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  output logic [CH0_BITS-1:0] wiper0,
  output logic [CH1_BITS-1:0] wiper1,
  output logic [CH2_BITS-1:0] wiper2
);

  localparam logic [3:0] ST_IDLE  = 4'd0;
  localparam logic [3:0] ST_ADDR  = 4'd1;
  localparam logic [3:0] ST_AACK  = 4'd2;
  localparam logic [3:0] ST_INSTR = 4'd3;
  localparam logic [3:0] ST_IACK  = 4'd4;
  localparam logic [3:0] ST_WDATA = 4'd5;
  localparam logic [3:0] ST_DACK  = 4'd6;
  localparam logic [3:0] ST_RDATA = 4'd7;
  localparam logic [3:0] ST_MACK  = 4'd8;
  localparam logic [3:0] ST_SKIP  = 4'd9;

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [7:0] TOP8     = 8'(CH1_TOP);
  localparam logic [CH1_BITS-1:0] TOPN = CH1_BITS'(CH1_TOP);

  logic [SYNC_DEPTH:0] scl_pipe, sda_pipe;
  logic scl_q, scl_p, sda_q, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  logic [3:0] state;
  logic [3:0] bitcnt;
  logic [7:0] sreg;
  logic [7:0] txreg;
  logic [1:0] ptr;
  logic       rw;
  logic       mack;
  logic [7:0] rd_byte;
  logic [CH1_BITS-1:0] ch1_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_DEPTH-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_DEPTH-1:0], sda_i};
    end
  end

  assign scl_q     = scl_pipe[SYNC_DEPTH-1];
  assign scl_p     = scl_pipe[SYNC_DEPTH];
  assign sda_q     = sda_pipe[SYNC_DEPTH-1];
  assign sda_p     = sda_pipe[SYNC_DEPTH];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

  assign ch1_val = (sreg > TOP8) ? TOPN : sreg[CH1_BITS-1:0];
  assign rd_byte = (ptr == 2'd0) ? 8'(wiper0) :
                   (ptr == 2'd1) ? 8'(wiper1) : 8'(wiper2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sreg   <= '0;
      txreg  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      wiper0 <= '0;
      wiper1 <= '0;
      wiper2 <= '0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_INSTR, ST_WDATA: begin
          if (scl_rise && bitcnt != LAST_BIT) begin
            sreg   <= {sreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == LAST_BIT) begin
            if (state == ST_ADDR) begin
              if (sreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= sreg[0];
                state  <= ST_AACK;
              end else begin
                state <= ST_SKIP;
              end
            end else if (state == ST_INSTR) begin
              if (sreg[1:0] != 2'b11) begin
                sda_oe <= 1'b1;
                ptr    <= sreg[1:0];
                state  <= ST_IACK;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_DACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bitcnt <= rw ? 4'd1 : 4'd0;
            if (rw) begin
              txreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_INSTR;
            end
          end
        end
        ST_IACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WDATA;
          end
        end
        ST_DACK: begin
          if (scl_rise) begin
            case (ptr)
              2'd0:    wiper0 <= sreg[CH0_BITS-1:0];
              2'd1:    wiper1 <= ch1_val;
              default: wiper2 <= sreg[CH2_BITS-1:0];
            endcase
          end else if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_SKIP;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              sda_oe <= ~txreg[6];
              txreg  <= {txreg[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_q;
          end else if (scl_fall) begin
            if (mack) begin
              txreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              bitcnt <= 4'd1;
              state  <= ST_RDATA;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_wiper_slave_chk.sv
module i2c_wiper_slave_chk #(
  parameter int CH0_BITS = 6,
  parameter int CH1_BITS = 7,
  parameter int CH2_BITS = 8,
  parameter int CH1_TOP  = 99
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_q,
  input logic                scl_fall,
  input logic [3:0]          state,
  input logic [3:0]          bitcnt,
  input logic [7:0]          sreg,
  input logic                sda_oe,
  input logic [CH0_BITS-1:0] wiper0,
  input logic [CH1_BITS-1:0] wiper1,
  input logic [CH2_BITS-1:0] wiper2
);

  localparam logic [CH1_BITS-1:0] TOPN = CH1_BITS'(CH1_TOP);

  assert_reset_floor_R7: assert property (@(posedge clk)
    !rst_n |=> (wiper0 == '0 && wiper1 == '0 && wiper2 == '0));

  assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_q);

  assert_ch1_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wiper1 <= TOPN);

  assert_reserved_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd3 && scl_fall && bitcnt == 4'd8 && sreg[1:0] == 2'b11) |=> !sda_oe);

  assert_commit_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wiper0) || !$stable(wiper1) || !$stable(wiper2)) |-> $past(state) == 4'd6);

  assert_drive_states_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == 4'd2 || state == 4'd4 || state == 4'd6 || state == 4'd7));

endmodule

bind i2c_wiper_slave i2c_wiper_slave_chk #(
  .CH0_BITS(CH0_BITS), .CH1_BITS(CH1_BITS), .CH2_BITS(CH2_BITS), .CH1_TOP(CH1_TOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .scl_fall(scl_fall), .state(state),
  .bitcnt(bitcnt), .sreg(sreg), .sda_oe(sda_oe),
  .wiper0(wiper0), .wiper1(wiper1), .wiper2(wiper2)
);

// File: tb/sim_i2c_wiper_slave.sv
module sim_i2c_wiper_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [5:0] wiper0;
  logic [6:0] wiper1;
  logic [7:0] wiper2;

  int checks = 0;
  int errors = 0;
  int r8_viol = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rd_val;
  string rd_tag;
  event rd_evt;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_wiper_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wiper0(wiper0), .wiper1(wiper1), .wiper2(wiper2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wt(Q);
    scl = 1'b1; wt(2 * Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wt(Q);
    scl = 1'b1; wt(Q);
    b = sda_line; wt(Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic master_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~master_ack);
  endtask

  task automatic write_chan(input logic [1:0] ch, input logic wt_bit, input logic [7:0] d);
    logic a;
    bus_start();
    send_byte(8'hAE, a); chk("R1 address ack", a, 1);
    send_byte({5'b0, wt_bit, ch}, a); chk("R2 instruction ack", a, 1);
    send_byte(d, a); chk("R4 data ack", a, 1);
    bus_stop();
  endtask

  task automatic read_chan(input logic [1:0] ch, input logic wt_bit, input logic [7:0] expv, input string tag);
    logic a;
    logic [7:0] v;
    exp_q.push_back(expv);
    bus_start();
    send_byte(8'hAE, a); chk("R1 address ack (dummy write)", a, 1);
    send_byte({5'b0, wt_bit, ch}, a); chk("R2 instruction ack (read)", a, 1);
    bus_start();
    send_byte(8'hAF, a); chk("R6 read address ack", a, 1);
    recv_byte(v, 1'b0);
    bus_stop();
    rd_val = v; rd_tag = tag;
    -> rd_evt;
    wt(1);
  endtask

  initial begin : monitor
    forever begin
      @(rd_evt);
      if (exp_q.size() == 0) begin
        chk({rd_tag, " unexpected read"}, 1, 0);
      end else begin
        chk(rd_tag, rd_val, exp_q.pop_front());
      end
    end
  end

  logic scl_d = 1'b1;
  logic oe_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_d && scl && scl_d) r8_viol++;
    scl_d <= scl;
    oe_d <= sda_oe;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic a;
    logic [7:0] v;
    wt(5);
    chk("R7 reset wiper0", wiper0, 0);
    chk("R7 reset wiper1", wiper1, 0);
    chk("R7 reset wiper2", wiper2, 0);
    chk("R8 released after reset", sda_oe, 0);
    rst_n = 1'b1;
    wt(5);

    write_chan(2'd2, 1'b0, 8'hA5);
    chk("R4 channel 2 stored", wiper2, 8'hA5);
    write_chan(2'd0, 1'b1, 8'hFF);
    chk("R5 channel 0 keeps 6 bits", wiper0, 6'h3F);
    chk("R2 write-type bit no effect on channel 2", wiper2, 8'hA5);
    write_chan(2'd1, 1'b0, 8'd200);
    chk("R5 channel 1 clamped to 99", wiper1, 7'd99);
    write_chan(2'd1, 1'b0, 8'd57);
    chk("R5 channel 1 in range", wiper1, 7'd57);
    write_chan(2'd2, 1'b0, 8'h5A);
    chk("R4 random-access replace", wiper2, 8'h5A);

    read_chan(2'd2, 1'b1, 8'h5A, "R6 read channel 2 with write-type set");
    read_chan(2'd0, 1'b0, 8'h3F, "R6 read channel 0 upper bits zero");
    read_chan(2'd1, 1'b0, 8'd57, "R6 read channel 1");

    bus_start();
    send_byte(8'hAE, a); chk("R1 address ack before reserved", a, 1);
    send_byte(8'h03, a); chk("R3 reserved code not acknowledged", a, 0);
    send_byte(8'h22, a); chk("R3 data after reserved ignored", a, 0);
    bus_stop();
    chk("R3 channel 0 unchanged", wiper0, 6'h3F);
    chk("R3 channel 1 unchanged", wiper1, 7'd57);
    chk("R3 channel 2 unchanged", wiper2, 8'h5A);
    exp_q.push_back(8'd57);
    bus_start();
    send_byte(8'hAF, a); chk("R6 direct read address ack", a, 1);
    recv_byte(v, 1'b0);
    bus_stop();
    rd_val = v; rd_tag = "R3 pointer kept after reserved code";
    -> rd_evt;
    wt(1);

    bus_start();
    send_byte(8'hA0, a); chk("R1 foreign address not acknowledged", a, 0);
    send_byte(8'h02, a); chk("R1 instruction ignored after mismatch", a, 0);
    send_byte(8'h11, a); chk("R1 data ignored after mismatch", a, 0);
    bus_stop();
    chk("R1 channel 2 untouched by foreign write", wiper2, 8'h5A);

    bus_start();
    send_byte(8'hAE, a); chk("R9 address ack before restart", a, 1);
    send_byte(8'h02, a); chk("R9 instruction ack before restart", a, 1);
    bus_start();
    send_byte(8'hAE, a); chk("R9 address ack after restart", a, 1);
    send_byte(8'h00, a); chk("R9 instruction ack after restart", a, 1);
    send_byte(8'h15, a); chk("R9 data ack after restart", a, 1);
    bus_stop();
    chk("R9 restart wrote channel 0", wiper0, 6'h15);
    chk("R9 channel 2 not written by aborted transfer", wiper2, 8'h5A);

    wt(4 * Q);
    chk("R8 SDA drive changes only while SCL low", r8_viol, 0);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule